// File: doc/BRIEF.md
# Dual-Issue Pairing Check Unit

This unit sits in the issue stage of a two-wide in-order core. Each cycle it receives two decoded instruction descriptors. The older one is headed for pipe 0 and the younger one for pipe 1. The unit decides whether both issue together or only the older one leaves. When the younger one is held back, the surrounding queue moves it up into the older slot for the next cycle. Decode, the execute pipes, branch prediction and operand-readiness interlocks live elsewhere.

The decision is made on the assumption that every instruction will execute. Condition codes therefore never relax a register hazard. Flags are produced in the second execute stage, which is also where conditional ALU work resolves. For that reason a conditional younger instruction cannot ride alongside an older instruction that sets flags. Two flag setters may still pair, and their flag results are merged with the younger one winning. A branch may pair in either slot, including behind a compare.

The decision and the flag-merge select are held in a one-cycle registered stage. That stage is built as a small state machine with three states:
- `ST_IDLE`: nothing issues.
- `ST_SOLO`: only pipe 0 issues.
- `ST_PAIR`: both pipes issue.

Every state can move to any state on the next clock, chosen by the current inputs:
- `ST_IDLE` is taken when the older slot is empty.
- `ST_SOLO` is taken when the older slot is valid but pairing is refused.
- `ST_PAIR` is taken when no rule refuses the pair.

Reset forces `ST_IDLE`.

Top module: `pair_issue_check`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `issue_old`, `issue_young` and `flag_src` are all zero.
- R2: If `old_valid` is low, neither pipe issues. If `old_valid` is high and `yng_valid` is low, only pipe 0 issues. If both are valid and no rule below refuses the pair, both issue.
- R3: If both descriptors write a destination (`*_dst_en` high) and the destination numbers are equal, the pair is refused. This holds whatever the `old_cond`/`yng_cond` bits say.
- R4: If any enabled younger source (bit i of `yng_src_en`, number in bits [i*REG_W +: REG_W] of `yng_src`) equals an enabled older destination, the pair is refused. Condition bits are ignored here too.
- R5: If the older descriptor sets flags and the younger one is conditional and not a branch, the pair is refused.
- R6: `flag_src` encodes 0 = no flag write, 1 = pipe 0 flags only, 2 = pipe 1 flags only, 3 = both merged with pipe 1 bits taking priority. When two flag setters pair, `flag_src` is 3. When only pipe 0 issues, `flag_src` is 1 if it sets flags and 0 otherwise.
- R7: A younger branch (`yng_branch`) pairs behind an older flag-setting compare even when the branch is conditional.
- R8: An older branch (`old_branch`) pairs with the following instruction; its branch bit never refuses a pair.
- R9: Unit class encoding is 0 = ALU, 1 = load/store, 2 = multiply, 3 = other. Two descriptors both in class 1, or both in class 2, are refused. Equal classes 0 or 3 may pair.
- R10: The outputs change only at a rising clock edge and reflect the descriptors presented at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| old_valid | input | 1 | Older slot holds an instruction |
| old_dst_en | input | 1 | Older writes a destination register |
| old_dst | input | REG_W | Older destination register number |
| old_sets_flags | input | 1 | Older updates the flags |
| old_cond | input | 1 | Older is conditionally executed |
| old_branch | input | 1 | Older is a branch |
| old_unit | input | UNIT_W | Older unit class |
| yng_valid | input | 1 | Younger slot holds an instruction |
| yng_dst_en | input | 1 | Younger writes a destination register |
| yng_dst | input | REG_W | Younger destination register number |
| yng_src_en | input | NSRC | Per-source read enables of the younger |
| yng_src | input | NSRC*REG_W | Younger source register numbers, packed |
| yng_sets_flags | input | 1 | Younger updates the flags |
| yng_cond | input | 1 | Younger is conditionally executed |
| yng_branch | input | 1 | Younger is a branch |
| yng_unit | input | UNIT_W | Younger unit class |
| issue_old | output | 1 | Pipe 0 issues this cycle |
| issue_young | output | 1 | Pipe 1 issues this cycle |
| flag_src | output | 2 | Flag write and merge select |

## Verification
The assertions assume that descriptor fields are only meaningful while the matching valid bit is high. They also assume that the encoding of the unit class is the one fixed in R9. The properties gate every rule on both valid bits, so unused fields may hold anything.

The stimulus draws register numbers from a small range so that destination and source collisions are frequent. It draws unit classes from the full four-value encoding and sets every control bit freely. Directed pairs cover each refusal rule once with the condition bits set in a way that would wrongly suggest a relaxation.

// File: rtl/pairing_pkg.sv
package pairing_pkg;

    // Unit class encoding of a descriptor.
    typedef enum logic [1:0] {
        UNIT_ALU  = 2'd0,
        UNIT_LSU  = 2'd1,
        UNIT_MUL  = 2'd2,
        UNIT_MISC = 2'd3
    } unit_e;

    // Flag write select handed to the second execute stage.
    typedef enum logic [1:0] {
        FLG_NONE  = 2'd0,
        FLG_OLD   = 2'd1,
        FLG_YOUNG = 2'd2,
        FLG_MERGE = 2'd3
    } flag_sel_e;

    // Registered issue outcome.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SOLO = 2'd1,
        ST_PAIR = 2'd2
    } issue_st_e;

    // Reasons a pair can be refused.
    typedef struct packed {
        logic waw;
        logic raw;
        logic flag;
        logic unit;
    } refuse_t;

endpackage

// File: rtl/pair_reg_hazard.sv
module pair_reg_hazard #(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                  old_dst_en,
    input  logic [REG_W-1:0]      old_dst,
    input  logic                  yng_dst_en,
    input  logic [REG_W-1:0]      yng_dst,
    input  logic [NSRC-1:0]       yng_src_en,
    input  logic [NSRC*REG_W-1:0] yng_src,
    output logic                  waw,
    output logic                  raw
);

    logic [NSRC-1:0] src_hit;

    // One comparator per younger source port.
    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            assign src_hit[i] = yng_src_en[i] && old_dst_en &&
                                (yng_src[i*REG_W +: REG_W] == old_dst);
        end
    endgenerate

    assign raw = |src_hit;
    assign waw = old_dst_en && yng_dst_en && (old_dst == yng_dst);

endmodule

// File: rtl/pair_unit_conflict.sv
module pair_unit_conflict #(
    parameter int                       UNIT_W      = 2,
    parameter logic [(1<<UNIT_W)-1:0]   SHARED_MASK = 4'b0110
) (
    input  logic [UNIT_W-1:0] old_unit,
    input  logic [UNIT_W-1:0] yng_unit,
    output logic              conflict
);

    localparam int NUM_UNITS = 1 << UNIT_W;

    logic [NUM_UNITS-1:0] class_hit;

    // A class with a single instance cannot serve both slots.
    generate
        for (genvar c = 0; c < NUM_UNITS; c++) begin : g_cls
            if (SHARED_MASK[c]) begin : g_single
                assign class_hit[c] = (old_unit == UNIT_W'(c)) &&
                                      (yng_unit == UNIT_W'(c));
            end else begin : g_multi
                assign class_hit[c] = 1'b0;
            end
        end
    endgenerate

    assign conflict = |class_hit;

endmodule

// File: rtl/pair_flag_rule.sv
module pair_flag_rule
    import pairing_pkg::*;
(
    input  logic      old_sets_flags,
    input  logic      yng_sets_flags,
    input  logic      yng_cond,
    input  logic      yng_branch,
    output logic      flag_block,
    output flag_sel_e sel_pair,
    output flag_sel_e sel_solo
);

    // Conditional ALU work resolves in the same stage that produces flags,
    // so it cannot consume flags made by its partner; branches are exempt.
    assign flag_block = old_sets_flags && yng_cond && !yng_branch;

    always_comb begin
        unique case ({old_sets_flags, yng_sets_flags})
            2'b11:   sel_pair = FLG_MERGE;
            2'b10:   sel_pair = FLG_OLD;
            2'b01:   sel_pair = FLG_YOUNG;
            default: sel_pair = FLG_NONE;
        endcase
        sel_solo = old_sets_flags ? FLG_OLD : FLG_NONE;
    end

endmodule

// File: rtl/pair_issue_check.sv
module pair_issue_check
    import pairing_pkg::*;
#(
    parameter int                     REG_W       = 5,
    parameter int                     NSRC        = 2,
    parameter int                     UNIT_W      = 2,
    parameter logic [(1<<UNIT_W)-1:0] SHARED_MASK = 4'b0110
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  old_valid,
    input  logic                  old_dst_en,
    input  logic [REG_W-1:0]      old_dst,
    input  logic                  old_sets_flags,
    input  logic                  old_cond,
    input  logic                  old_branch,
    input  logic [UNIT_W-1:0]     old_unit,
    input  logic                  yng_valid,
    input  logic                  yng_dst_en,
    input  logic [REG_W-1:0]      yng_dst,
    input  logic [NSRC-1:0]       yng_src_en,
    input  logic [NSRC*REG_W-1:0] yng_src,
    input  logic                  yng_sets_flags,
    input  logic                  yng_cond,
    input  logic                  yng_branch,
    input  logic [UNIT_W-1:0]     yng_unit,
    output logic                  issue_old,
    output logic                  issue_young,
    output logic [1:0]            flag_src
);

    refuse_t   why;
    flag_sel_e sel_pair;
    flag_sel_e sel_solo;
    logic      refuse;
    issue_st_e state_q;
    issue_st_e state_d;
    flag_sel_e flag_q;
    flag_sel_e flag_d;

    // Older condition and branch bits never influence pairing (R3, R8).
    logic unused_old_ctl;
    assign unused_old_ctl = old_cond ^ old_branch;

    pair_reg_hazard #(
        .REG_W (REG_W),
        .NSRC  (NSRC)
    ) u_reg (
        .old_dst_en (old_dst_en),
        .old_dst    (old_dst),
        .yng_dst_en (yng_dst_en),
        .yng_dst    (yng_dst),
        .yng_src_en (yng_src_en),
        .yng_src    (yng_src),
        .waw        (why.waw),
        .raw        (why.raw)
    );

    pair_unit_conflict #(
        .UNIT_W      (UNIT_W),
        .SHARED_MASK (SHARED_MASK)
    ) u_unit (
        .old_unit (old_unit),
        .yng_unit (yng_unit),
        .conflict (why.unit)
    );

    pair_flag_rule u_flag (
        .old_sets_flags (old_sets_flags),
        .yng_sets_flags (yng_sets_flags),
        .yng_cond       (yng_cond),
        .yng_branch     (yng_branch),
        .flag_block     (why.flag),
        .sel_pair       (sel_pair),
        .sel_solo       (sel_solo)
    );

    assign refuse = !yng_valid || (|why);

    // Next-state selection.
    always_comb begin
        state_d = ST_IDLE;
        flag_d  = FLG_NONE;
        if (old_valid) begin
            if (refuse) begin
                state_d = ST_SOLO;
                flag_d  = sel_solo;
            end else begin
                state_d = ST_PAIR;
                flag_d  = sel_pair;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            flag_q  <= FLG_NONE;
        end else begin
            state_q <= state_d;
            flag_q  <= flag_d;
        end
    end

    // Output decode.
    always_comb begin
        issue_old   = 1'b0;
        issue_young = 1'b0;
        flag_src    = 2'b00;
        unique case (state_q)
            ST_IDLE: begin
                issue_old   = 1'b0;
                issue_young = 1'b0;
            end
            ST_SOLO: begin
                issue_old   = 1'b1;
                issue_young = 1'b0;
                flag_src    = flag_q;
            end
            ST_PAIR: begin
                issue_old   = 1'b1;
                issue_young = 1'b1;
                flag_src    = flag_q;
            end
            default: begin
                issue_old   = 1'b0;
                issue_young = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pair_issue_checker.sv
module pair_issue_checker #(
    parameter int REG_W  = 5,
    parameter int NSRC   = 2,
    parameter int UNIT_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  old_valid,
    input logic                  old_dst_en,
    input logic [REG_W-1:0]      old_dst,
    input logic                  old_sets_flags,
    input logic [UNIT_W-1:0]     old_unit,
    input logic                  yng_valid,
    input logic                  yng_dst_en,
    input logic [REG_W-1:0]      yng_dst,
    input logic [NSRC-1:0]       yng_src_en,
    input logic [NSRC*REG_W-1:0] yng_src,
    input logic                  yng_sets_flags,
    input logic                  yng_cond,
    input logic                  yng_branch,
    input logic [UNIT_W-1:0]     yng_unit,
    input logic                  issue_old,
    input logic                  issue_young,
    input logic [1:0]            flag_src
);

    logic both;
    logic any_raw;
    assign both = old_valid && yng_valid;

    always_comb begin
        any_raw = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (yng_src_en[i] && old_dst_en && yng_src[i*REG_W +: REG_W] == old_dst) begin
                any_raw = 1'b1;
            end
        end
    end

    a_r2_empty_old: assert property (@(posedge clk) disable iff (!rst_n)
        !old_valid |=> (!issue_old && !issue_young));

    a_r2_young_needs_old: assert property (@(posedge clk) disable iff (!rst_n)
        issue_young |-> issue_old);

    a_r3_same_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (both && old_dst_en && yng_dst_en && old_dst == yng_dst) |=> !issue_young);

    a_r4_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (both && any_raw) |=> !issue_young);

    a_r5_flag_use: assert property (@(posedge clk) disable iff (!rst_n)
        (both && old_sets_flags && yng_cond && !yng_branch) |=> !issue_young);

    a_r6_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (both && old_sets_flags && yng_sets_flags) |=> (!issue_young || flag_src == 2'd3));

    a_r6_solo_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_old && !issue_young) |-> (flag_src == 2'd0 || flag_src == 2'd1));

    a_r9_single_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (both && old_unit == yng_unit && (old_unit == 2'd1 || old_unit == 2'd2)) |=> !issue_young);

    a_r1_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_old |-> (flag_src == 2'd0));

endmodule

bind pair_issue_check pair_issue_checker #(
    .REG_W  (REG_W),
    .NSRC   (NSRC),
    .UNIT_W (UNIT_W)
) u_chk (.*);

// File: tb/test_pair_issue_check.sv
module test_pair_issue_check;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       o_v, o_de, o_sf, o_c, o_b;
    logic [4:0] o_d;
    logic [1:0] o_u;
    logic       y_v, y_de, y_sf, y_c, y_b;
    logic [4:0] y_d;
    logic [1:0] y_se;
    logic [9:0] y_s;
    logic [1:0] y_u;
    logic       iss_o, iss_y;
    logic [1:0] fsrc;

    int vectors = 0;
    int misses  = 0;

    always #(CLK_P/2) clk = ~clk;

    pair_issue_check i_pair_issue_check (
        .clk(clk), .rst_n(rst_n),
        .old_valid(o_v), .old_dst_en(o_de), .old_dst(o_d),
        .old_sets_flags(o_sf), .old_cond(o_c), .old_branch(o_b), .old_unit(o_u),
        .yng_valid(y_v), .yng_dst_en(y_de), .yng_dst(y_d),
        .yng_src_en(y_se), .yng_src(y_s), .yng_sets_flags(y_sf),
        .yng_cond(y_c), .yng_branch(y_b), .yng_unit(y_u),
        .issue_old(iss_o), .issue_young(iss_y), .flag_src(fsrc)
    );

    // Behavioural expectation from the requirements: {old, young, flags}.
    function automatic logic [3:0] expect_now();
        bit block = 0;
        bit e_o = o_v;
        bit e_y = 0;
        int fl = 0;
        if (o_v) begin
            if (!y_v) block = 1;
            if (o_de && y_de && o_d == y_d) block = 1;
            for (int i = 0; i < 2; i++)
                if (y_se[i] && o_de && y_s[i*5 +: 5] == o_d) block = 1;
            if (o_sf && y_c && !y_b) block = 1;
            if (o_u == y_u && (o_u == 1 || o_u == 2)) block = 1;
            e_y = !block;
            if (e_y) fl = (o_sf ? 1 : 0) + (y_sf ? 2 : 0);
            else     fl = o_sf ? 1 : 0;
        end
        return {e_o, e_y, 2'(fl)};
    endfunction

    task automatic compare(input string tag, input logic [3:0] exp);
        vectors++;
        if ({iss_o, iss_y, fsrc} !== exp) begin
            misses++;
            $display("FAIL %s: got old=%0b young=%0b flags=%0d exp old=%0b young=%0b flags=%0d",
                     tag, iss_o, iss_y, fsrc, exp[3], exp[2], exp[1:0]);
        end
    endtask

    // Apply current inputs across one edge; check against the model and
    // optionally against a stated pair outcome (-1 = model only).
    task automatic step(input string tag, input int want_pair);
        logic [3:0] exp = expect_now();
        @(posedge clk);
        #1;
        compare(tag, exp);
        if (want_pair >= 0) begin
            vectors++;
            if (iss_y !== want_pair[0]) begin
                misses++;
                $display("FAIL %s: got pair=%0b exp pair=%0b", tag, iss_y, want_pair[0]);
            end
        end
    endtask

    task automatic base();
        o_v = 1; o_de = 1; o_d = 5'd1; o_sf = 0; o_c = 0; o_b = 0; o_u = 2'd0;
        y_v = 1; y_de = 1; y_d = 5'd2; y_se = 2'b11; y_s = {5'd4, 5'd3};
        y_sf = 0; y_c = 0; y_b = 0; y_u = 2'd0;
    endtask

    initial begin
        #(CLK_P * 150000);
        misses++;
        $display("FAIL watchdog: got hang exp finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        base();
        // R1: reset holds outputs low even with a pairable input.
        repeat (3) @(posedge clk);
        #1;
        compare("R1 in reset", 4'b0000);
        rst_n = 1'b1;
        o_v = 0;
        step("R1 after reset", 0);

        base(); o_v = 0;                 step("R2 old empty", 0);
        base(); y_v = 0;                 step("R2 young empty", 0);
        base();                          step("R2 clean pair", 1);
        base(); y_d = 5'd1; o_c = 1; y_c = 1; step("R3 same dest cond", 0);
        base(); y_d = 5'd1; y_de = 0;    step("R3 young no write", 1);
        base(); y_s = {5'd4, 5'd1};      step("R4 raw src0", 0);
        base(); y_s = {5'd1, 5'd3}; y_c = 1; step("R4 raw src1 cond", 0);
        base(); y_s = {5'd1, 5'd1}; y_se = 2'b00; step("R4 src disabled", 1);
        base(); o_sf = 1; y_c = 1;       step("R5 flag consumer", 0);
        base(); o_sf = 1;                step("R5 uncond after setter", 1);
        base(); o_sf = 1; y_sf = 1;      step("R6 merged flags", 1);
        base(); o_sf = 1; y_sf = 1; y_u = 2'd1; o_u = 2'd1; step("R6 solo flags", 0);
        base(); y_sf = 1;                step("R6 young flags", 1);
        base(); o_sf = 1; o_de = 0; y_b = 1; y_c = 1; y_de = 0; y_u = 2'd3;
                                         step("R7 branch after compare", 1);
        base(); o_b = 1; o_de = 0; o_u = 2'd3; step("R8 older branch", 1);
        base(); o_u = 2'd1; y_u = 2'd1;  step("R9 two lsu", 0);
        base(); o_u = 2'd2; y_u = 2'd2;  step("R9 two mul", 0);
        base(); o_u = 2'd3; y_u = 2'd3;  step("R9 two misc", 1);
        base(); o_u = 2'd1; y_u = 2'd2;  step("R9 lsu mul", 1);

        // R10: a new input does not show before the next edge.
        base(); step("R10 setup", 1);
        y_d = 5'd1;
        #2;
        vectors++;
        if (iss_y !== 1'b1) begin
            misses++;
            $display("FAIL R10 early change: got pair=%0b exp pair=1", iss_y);
        end
        step("R10 after edge", 0);

        for (int n = 0; n < 3000; n++) begin
            o_v = ($urandom % 8) != 0; y_v = ($urandom % 8) != 0;
            o_de = 1'($urandom); y_de = 1'($urandom);
            o_d = 5'($urandom % 6); y_d = 5'($urandom % 6);
            y_se = 2'($urandom); y_s = {5'($urandom % 6), 5'($urandom % 6)};
            o_sf = 1'($urandom); y_sf = 1'($urandom);
            o_c = 1'($urandom); y_c = 1'($urandom);
            o_b = 1'($urandom); y_b = 1'($urandom);
            o_u = 2'($urandom); y_u = 2'($urandom);
            step("random (R10)", -1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule